// File: doc/BRIEF.md
# Filter Bandwidth Linear Search Calibrator

This block tunes the bank control word of an on-chip filter by a downward linear search. On a start pulse it asks an external tone source for a fixed low-frequency tone and records the amplitude reading that comes back as the reference level. It then loads the selected control field with its starting value, asks for a tone at half the selected bandwidth, and reads the amplitude once per step. The word is stepped down by one after every reading that falls below the reference. The search ends on the first reading at or above the reference, or when a reading at word zero is still below it.

The band input, in MHz, picks one of two control fields. Narrow bands use an 11-bit field and wide bands use an 8-bit field, and each has its own start value. After every tone acknowledge and every change of the word, the block ignores the amplitude strobe for a settle count given at an input. The word found stays on the control output, and a result register keeps it together with a pass flag.

Top module: `bwc_search_cal`

## Requirements
- R1: While reset is held low and after it is released, busy, done and tone_req are 0, and ctrl_word, ctrl_field, result_word and result_ok are 0.
- R2: A start pulse sampled while the block is idle raises tone_req with tone_khz = 100. tone_req stays high until tone_ack is sampled high. The first amplitude sample accepted after that becomes the reference.
- R3: If band_mhz <= 20, the low field is used: ctrl_field = 0, and ctrl_word is loaded with 0x0FF (11 bits wide). Otherwise the high field is used: ctrl_field = 1, and ctrl_word is loaded with 0x7FF truncated to 8 bits, which is 0xFF.
- R4: After the reference is captured, the block loads ctrl_word with the start value and raises tone_req a second time, with tone_khz = band_mhz * 500 (half the bandwidth, in kHz).
- R5: An accepted search sample with amp >= reference, including the equal case, ends the search with result_ok = 1 and result_word equal to the current ctrl_word.
- R6: An accepted search sample below the reference, taken while ctrl_word is nonzero, lowers ctrl_word by exactly one. ctrl_word changes in no other way during a search.
- R7: An accepted sample below the reference taken at ctrl_word = 0 ends the search with result_ok = 0 and result_word = 0.
- R8: After each tone acknowledge and each decrement, amp_valid is ignored on the next settle_cnt rising edges. With amp_valid held high, done therefore rises 2*S + 4 + n*(S + 1) edges after the start edge, where S is settle_cnt and n is the number of decrements.
- R9: done is a one-cycle pulse. busy is high from the start edge until done. ctrl_word keeps the value found after done.
- R10: A start pulse sampled while busy has no effect on the running search, on its timing or on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a calibration when idle |
| band_mhz | input | 7 | Target bandwidth in MHz |
| settle_cnt | input | 8 | Edges to ignore after each tone or word change |
| tone_req | output | 1 | Tone request, held until acknowledged |
| tone_khz | output | 16 | Requested tone frequency in kHz |
| tone_ack | input | 1 | Tone source acknowledge |
| amp | input | 16 | Measured signal-strength reading |
| amp_valid | input | 1 | amp holds a valid reading |
| ctrl_word | output | 11 | Filter bank control word (high field zero-extended) |
| ctrl_field | output | 1 | 0: low-band field, 1: high-band field |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| result_word | output | 11 | Latched control word found |
| result_ok | output | 1 | Latched pass flag |

## Verification
The hardest conditions to reach from the ports are the failure exit at word zero after a full 255-step descent and the exact count of ignored strobes after each change of the word. The bench models the filter as an amplitude source that follows ctrl_word against a chosen threshold. The reading equals the reference exactly when the word is at or below the threshold, which also tests the equal case. Because amp_valid is held high throughout, every ignored edge adds to the measured start-to-done latency. With the threshold set unreachable, the full descent ends in failure at zero.

// File: rtl/bwc_pkg.sv
// Shared types for the bandwidth search calibrator.
// Assumes: none beyond a single clock domain.
package bwc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF_TONE,
        ST_REF_WAIT,
        ST_SRCH_TONE,
        ST_SRCH_WAIT
    } cal_state_t;

endpackage

// File: rtl/bwc_settle_timer.sv
// Settle timer: loaded with a count, it counts down to zero and then
// reports ready. Assumes load and countdown never need to run at once.
module bwc_settle_timer #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    output logic          ready
);

    logic [SW-1:0] cnt;

    // Countdown register: load on request, otherwise step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - SW'(1);
        end
    end

    assign ready = (cnt == '0);

    // R8: once ready, only a new load can drop readiness.
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !load) |=> ready);

    // R8: a nonzero load always withdraws readiness on the next cycle.
    a_r8_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !ready);

endmodule

// File: rtl/bwc_ctrl_word.sv
// Control word register: loads the start value of the chosen field, or
// steps down by one. Assumes dec is never asserted at zero.
module bwc_ctrl_word #(
    parameter int LO_W     = 11,
    parameter int HI_W     = 8,
    parameter int LO_START = 'h0FF,
    parameter int HI_START = 'h7FF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     sel_hi,
    input  logic                     dec,
    output logic [((LO_W > HI_W) ? LO_W : HI_W)-1:0] word
);

    localparam int CW = (LO_W > HI_W) ? LO_W : HI_W;
    localparam logic [LO_W-1:0] LO_INIT = LO_W'(LO_START);
    localparam logic [HI_W-1:0] HI_INIT = HI_W'(HI_START);

    logic [CW-1:0] lo_ext;
    logic [CW-1:0] hi_ext;

    // Zero-extend each field's start value to the shared word width.
    generate
        if (LO_W == CW) begin : g_lo_full
            assign lo_ext = LO_INIT;
        end else begin : g_lo_pad
            assign lo_ext = {{(CW-LO_W){1'b0}}, LO_INIT};
        end
        if (HI_W == CW) begin : g_hi_full
            assign hi_ext = HI_INIT;
        end else begin : g_hi_pad
            assign hi_ext = {{(CW-HI_W){1'b0}}, HI_INIT};
        end
    endgenerate

    // Word register: field start value on load, minus one on dec.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word <= sel_hi ? hi_ext : lo_ext;
        end else if (dec) begin
            word <= word - CW'(1);
        end
    end

    // R6: every decrement moves the word down by exactly one.
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (word == $past(word) - CW'(1)));

    // R6: without load or decrement the word holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(word));

    // R3: a high-field load never exceeds the 8-bit field.
    a_r3_hi_width: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel_hi) |=> (word <= CW'((1 << HI_W) - 1)));

endmodule

// File: rtl/bwc_result_reg.sv
// Result register: keeps the word found and the pass flag from the most
// recent completed search. Assumes capture is a single-cycle strobe.
module bwc_result_reg #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [CW-1:0] word_in,
    input  logic          ok_in,
    output logic [CW-1:0] word_out,
    output logic          ok_out
);

    // Result latch: update only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            ok_out   <= 1'b0;
        end else if (capture) begin
            word_out <= word_in;
            ok_out   <= ok_in;
        end
    end

    // R9: results are held between captures.
    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(word_out) && $stable(ok_out)));

endmodule

// File: rtl/bwc_search_cal.sv
// Bandwidth search calibrator top: captures a reference amplitude under a
// low tone, then steps the filter control word down from its start value
// until the measured amplitude meets the reference or the word hits zero.
// Assumes the tone source holds the tone until the next request and that
// settle_cnt is stable during a calibration.
module bwc_search_cal
    import bwc_pkg::*;
#(
    parameter int LO_W         = 11,
    parameter int HI_W         = 8,
    parameter int LO_START     = 'h0FF,
    parameter int HI_START     = 'h7FF,
    parameter int BAND_W       = 7,
    parameter int LO_BAND_MAX  = 20,
    parameter int AMP_W        = 16,
    parameter int SET_W        = 8,
    parameter int FREQ_W       = 16,
    parameter int REF_TONE_KHZ = 100,
    parameter int HALF_KHZ     = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BAND_W-1:0] band_mhz,
    input  logic [SET_W-1:0]  settle_cnt,
    output logic              tone_req,
    output logic [FREQ_W-1:0] tone_khz,
    input  logic              tone_ack,
    input  logic [AMP_W-1:0]  amp,
    input  logic              amp_valid,
    output logic [((LO_W > HI_W) ? LO_W : HI_W)-1:0] ctrl_word,
    output logic              ctrl_field,
    output logic              busy,
    output logic              done,
    output logic [((LO_W > HI_W) ? LO_W : HI_W)-1:0] result_word,
    output logic              result_ok
);

    localparam int CW = (LO_W > HI_W) ? LO_W : HI_W;
    localparam logic [BAND_W-1:0] BAND_LIM = BAND_W'(LO_BAND_MAX);
    localparam logic [FREQ_W-1:0] REF_KHZ  = FREQ_W'(REF_TONE_KHZ);

    cal_state_t        state;
    logic [AMP_W-1:0]  ref_amp;
    logic [BAND_W-1:0] band_lat;
    logic              sel_hi;
    logic [FREQ_W-1:0] tone_q;
    logic              done_q;

    logic timer_ready;
    logic timer_load;
    logic accept;
    logic tone_phase;
    logic word_load;
    logic word_dec;
    logic below_ref;
    logic finish;

    // Step decode: which events move the timer, the word and the result.
    always_comb begin
        tone_phase = (state == ST_REF_TONE) || (state == ST_SRCH_TONE);
        accept     = amp_valid && timer_ready;
        below_ref  = (amp < ref_amp);
        word_load  = (state == ST_REF_WAIT) && accept;
        word_dec   = (state == ST_SRCH_WAIT) && accept && below_ref &&
                     (ctrl_word != '0);
        finish     = (state == ST_SRCH_WAIT) && accept && !word_dec;
        timer_load = (tone_phase && tone_ack) || word_dec;
    end

    // Sequencer: reference phase, then search phase, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ref_amp  <= '0;
            band_lat <= '0;
            sel_hi   <= 1'b0;
            tone_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_REF_TONE;
                        band_lat <= band_mhz;
                        sel_hi   <= (band_mhz > BAND_LIM);
                        tone_q   <= REF_KHZ;
                    end
                end
                ST_REF_TONE: begin
                    if (tone_ack) state <= ST_REF_WAIT;
                end
                ST_REF_WAIT: begin
                    if (accept) begin
                        ref_amp <= amp;
                        tone_q  <= FREQ_W'(int'(band_lat) * HALF_KHZ);
                        state   <= ST_SRCH_TONE;
                    end
                end
                ST_SRCH_TONE: begin
                    if (tone_ack) state <= ST_SRCH_WAIT;
                end
                ST_SRCH_WAIT: begin
                    if (finish) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    bwc_settle_timer #(
        .SW(SET_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (settle_cnt),
        .ready    (timer_ready)
    );

    bwc_ctrl_word #(
        .LO_W     (LO_W),
        .HI_W     (HI_W),
        .LO_START (LO_START),
        .HI_START (HI_START)
    ) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (word_load),
        .sel_hi (sel_hi),
        .dec    (word_dec),
        .word   (ctrl_word)
    );

    bwc_result_reg #(
        .CW(CW)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (finish),
        .word_in  (ctrl_word),
        .ok_in    (!below_ref),
        .word_out (result_word),
        .ok_out   (result_ok)
    );

    assign tone_req   = tone_phase;
    assign tone_khz   = tone_q;
    assign ctrl_field = sel_hi;
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;

    // R2: a tone request stays up until it is acknowledged.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_req && !tone_ack) |=> tone_req);

    // R9: done lasts a single cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a failed search always reports word zero.
    a_r7_fail_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !result_ok) |-> (result_word == '0));

    // R5: a completed search leaves the found word on the control output.
    a_r5_word_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result_word == ctrl_word));

    // R8: while settling, the word does not move and the search cannot end.
    a_r8_settle_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRCH_WAIT && !timer_ready) |=> ($stable(ctrl_word) && !done));

    // R10: a start while busy leaves the reference tone request unrepeated.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRCH_WAIT) |=> (state != ST_REF_TONE));

endmodule

// File: tb/tb_bwc_search_cal.sv
// Directed bench for the bandwidth search calibrator.
module tb_bwc_search_cal;

    localparam logic [15:0] REF_AMP = 16'd1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [6:0]  band_mhz;
    logic [7:0]  settle_cnt;
    logic        tone_req;
    logic [15:0] tone_khz;
    logic        tone_ack;
    logic [15:0] amp;
    logic        amp_valid;
    logic [10:0] ctrl_word;
    logic        ctrl_field;
    logic        busy;
    logic        done;
    logic [10:0] result_word;
    logic        result_ok;

    int n_chk = 0;
    int n_bad = 0;
    int thr = 0;
    bit thr_never = 1'b0;
    int req_count = 0;
    int tlog0 = 0;
    int tlog1 = 0;
    int steps = 0;
    int odd_moves = 0;
    logic [10:0] prev_word = '0;

    always #2.5 clk = ~clk;

    bwc_search_cal dut (
        .clk(clk), .rst_n(rst_n), .start(start), .band_mhz(band_mhz),
        .settle_cnt(settle_cnt), .tone_req(tone_req), .tone_khz(tone_khz),
        .tone_ack(tone_ack), .amp(amp), .amp_valid(amp_valid),
        .ctrl_word(ctrl_word), .ctrl_field(ctrl_field), .busy(busy),
        .done(done), .result_word(result_word), .result_ok(result_ok)
    );

    // Tone source and filter model: ack follows request; amplitude meets
    // the reference exactly when the word is at or below the threshold.
    always @(negedge clk) begin
        if (tone_req) begin
            if (req_count == 0) tlog0 = int'(tone_khz);
            if (req_count == 1) tlog1 = int'(tone_khz);
            req_count++;
        end
        if (ctrl_word != prev_word) begin
            if (ctrl_word == prev_word - 11'd1) steps++;
            else if (ctrl_word != 11'h0FF) odd_moves++;
        end
        prev_word = ctrl_word;
        tone_ack  = tone_req;
        amp_valid = 1'b1;
        if (tone_khz == 16'd100) amp = REF_AMP;
        else if (!thr_never && int'(ctrl_word) <= thr) amp = REF_AMP;
        else amp = REF_AMP - 16'd1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0; start = 1'b0; band_mhz = '0; settle_cnt = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 tone_req", int'(tone_req), 0);
        chk("R1 ctrl_word", int'(ctrl_word), 0);
        chk("R1 ctrl_field", int'(ctrl_field), 0);
        chk("R1 result_word", int'(result_word), 0);
        chk("R1 result_ok", int'(result_ok), 0);
    endtask

    task automatic run_cal(input string name, input int band, input int s,
                           input int t, input bit never, input int exp_word,
                           input int exp_ok, input bit poke);
        int c;
        int exp_n;
        exp_n = exp_ok ? (255 - exp_word) : 255;
        settle_cnt = 8'(s); thr = t; thr_never = never;
        req_count = 0; steps = 0; odd_moves = 0;
        @(negedge clk);
        band_mhz = 7'(band); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk({name, " R9 busy after start"}, int'(busy), 1);
        c = 0;
        forever begin
            @(posedge clk);
            c++;
            @(negedge clk);
            if (poke) start = (c == 6) || (c == 20);
            if (done) break;
            if (c > 100000) begin
                chk({name, " watchdog"}, c, 0);
                break;
            end
        end
        start = 1'b0;
        chk({name, " R8 latency"}, c, 2*s + 4 + exp_n*(s + 1));
        chk({name, " R5/R7 result_ok"}, int'(result_ok), exp_ok);
        chk({name, " R5/R7 result_word"}, int'(result_word), exp_word);
        chk({name, " R6 steps"}, steps, exp_n);
        chk({name, " R6 odd moves"}, odd_moves, 0);
        chk({name, " R2 requests"}, req_count, 2);
        chk({name, " R2 ref tone"}, tlog0, 100);
        chk({name, " R4 search tone"}, tlog1, band * 500);
        chk({name, " R3 field"}, int'(ctrl_field), (band > 20) ? 1 : 0);
        chk({name, " R9 busy at done"}, int'(busy), 0);
        if (poke) chk({name, " R10 result unaffected"}, int'(result_word), exp_word);
        @(negedge clk);
        chk({name, " R9 done pulse"}, int'(done), 0);
        repeat (3) @(negedge clk);
        chk({name, " R9 word held"}, int'(ctrl_word), exp_word);
    endtask

    task automatic test_low_band();
        run_cal("low band", 10, 2, 100, 1'b0, 100, 1, 1'b0);
    endtask

    task automatic test_high_band();
        run_cal("high band", 40, 1, 50, 1'b0, 50, 1, 1'b0);
    endtask

    task automatic test_edge_20_immediate();
        run_cal("band 20 first hit", 20, 0, 2000, 1'b0, 255, 1, 1'b0);
    endtask

    task automatic test_fail_zero();
        run_cal("band 21 R7 fail", 21, 3, 0, 1'b1, 0, 0, 1'b0);
    endtask

    task automatic test_equal_at_zero();
        run_cal("R5 equal at zero", 5, 0, 0, 1'b0, 0, 1, 1'b0);
    endtask

    task automatic test_start_while_busy();
        run_cal("R10 restart ignored", 64, 1, 200, 1'b0, 200, 1, 1'b1);
    endtask

    initial begin
        tone_ack = 1'b0; amp = '0; amp_valid = 1'b0;
        test_reset();
        test_low_band();
        test_high_band();
        test_edge_20_immediate();
        test_fail_zero();
        test_equal_at_zero();
        test_start_while_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule